// File: doc/BRIEF.md
# Two-Wide Associative Recursion Engine

This block evaluates a first-order recursion y[k] = f(y[k-1], x[k]) with a nonlinear operator f and accepts two samples in every clock cycle. The operator must be associative. This lets the block reorder the work. The two fresh samples are combined with each other in a feedforward stage first. After that, only a single application of f remains inside the feedback loop. The feedforward stage is pipelined by one register, so the loop path holds one operator, not the two that a plain doubled loop would chain.

A parameter selects the operator: maximum, minimum, or unsigned saturating add. The data is unsigned. Each accepted pair produces two outputs:
- The even output is the state after the first sample.
- The odd output is the state after both samples.

The odd output is written back as the new state. A synchronous clear restarts the recursion from the identity element of the selected operator. The clear travels with the pair it arrives with, so that pair is the first one computed from the identity.

Top module: `assoc_unfold2`

## Requirements
- R1: While and after reset, before any pair is accepted, `valid_o` is 0, both data outputs are 0, and the state is the operator's identity. The identity is 0 for maximum and saturating add, and all ones for minimum.
- R2: For an accepted pair (x0, x1) with prior state s, `even_o` equals f(s, x0).
- R3: For the same pair, `odd_o` equals f(f(s, x0), x1). The state becomes `odd_o`, so the next pair starts from it.
- R4: `valid_o` is high exactly two clock cycles after `valid_i` was high. Two outputs are produced for every pair.
- R5: When `clr_i` is high, the state is reloaded with the identity. If `valid_i` is high in the same cycle, that pair is computed from the identity rather than from the old state.
- R6: A cycle with `valid_i` and `clr_i` both low leaves the state unchanged. The next pair continues from the previous odd output.
- R7: With OP = 2, a sum above 2^W-1 yields exactly 2^W-1 and never wraps.
- R8: OP = 0 selects maximum, OP = 1 selects minimum, and OP = 2 selects unsigned saturating add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous restart of the recursion from the identity |
| valid_i | input | 1 | The sample pair is present |
| x0_i | input | W | Earlier sample of the pair |
| x1_i | input | W | Later sample of the pair |
| valid_o | output | 1 | The output pair is present |
| even_o | output | W | State after the earlier sample |
| odd_o | output | W | State after the later sample |

## Verification
The restart and the arrival of a pair can fall in the same cycle. In that case the block must discard the old state for that very pair and must not apply the restart one pair late. The bench provokes this by asserting the clear with a valid pair while the state is far from the identity, and also during idle cycles and back-to-back with further pairs. Every output is compared against a serial model that applies f one sample at a time and resets its own state at the clear. This checks the regrouped datapath against the unregrouped definition for all three operators at once.

// File: rtl/assoc_unfold2_pkg.sv
package assoc_unfold2_pkg;
  localparam int OP_MAX = 0;
  localparam int OP_MIN = 1;
  localparam int OP_SAT = 2;

  function automatic logic [63:0] op_identity(input int op, input int w);
    logic [63:0] r;
    r = '0;
    if (op == OP_MIN) begin
      for (int i = 0; i < w; i++) r[i] = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/assoc_op.sv
module assoc_op #(
  parameter int W  = 16,
  parameter int OP = 0
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  import assoc_unfold2_pkg::*;

  generate
    if (OP == OP_MAX) begin : g_max
      assign y_o = (a_i > b_i) ? a_i : b_i;
    end else if (OP == OP_MIN) begin : g_min
      assign y_o = (a_i < b_i) ? a_i : b_i;
    end else begin : g_sat
      logic [W:0] sum;
      assign sum = {1'b0, a_i} + {1'b0, b_i};
      assign y_o = sum[W] ? {W{1'b1}} : sum[W-1:0];

      // result never falls below an operand (no wrap)
      always_comb begin
        if (!$isunknown({a_i, b_i}))
          p_no_wrap_r7: assert (y_o >= a_i && y_o >= b_i);
      end
    end
  endgenerate
endmodule

// File: rtl/pair_precombine.sv
module pair_precombine #(
  parameter int W  = 16,
  parameter int OP = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         valid_i,
  input  logic [W-1:0] x0_i,
  input  logic [W-1:0] x1_i,
  output logic         clr_q_o,
  output logic         vld_q_o,
  output logic [W-1:0] x0_q_o,
  output logic [W-1:0] pre_q_o
);
  logic [W-1:0] pre_d;

  assoc_op #(.W(W), .OP(OP)) u_pre (.a_i(x0_i), .b_i(x1_i), .y_o(pre_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_q_o <= 1'b0;
      vld_q_o <= 1'b0;
      x0_q_o  <= '0;
      pre_q_o <= '0;
    end else begin
      clr_q_o <= clr_i;
      vld_q_o <= valid_i;
      if (valid_i) begin
        x0_q_o  <= x0_i;
        pre_q_o <= pre_d;
      end
    end
  end
endmodule

// File: rtl/loop_stage.sv
module loop_stage #(
  parameter int W  = 16,
  parameter int OP = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_q_i,
  input  logic         vld_q_i,
  input  logic [W-1:0] x0_q_i,
  input  logic [W-1:0] pre_q_i,
  output logic         valid_o,
  output logic [W-1:0] even_o,
  output logic [W-1:0] odd_o
);
  import assoc_unfold2_pkg::*;

  localparam logic [W-1:0] IDENT = W'(op_identity(OP, W));

  logic [W-1:0] state_q, base, even_d, odd_d;

  // clear travels with its pair: that pair starts from identity
  assign base = clr_q_i ? IDENT : state_q;

  assoc_op #(.W(W), .OP(OP)) u_even (.a_i(base), .b_i(x0_q_i),  .y_o(even_d));
  assoc_op #(.W(W), .OP(OP)) u_odd  (.a_i(base), .b_i(pre_q_i), .y_o(odd_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= IDENT;
      valid_o <= 1'b0;
      even_o  <= '0;
      odd_o   <= '0;
    end else begin
      valid_o <= vld_q_i;
      if (vld_q_i) begin
        state_q <= odd_d;
        even_o  <= even_d;
        odd_o   <= odd_d;
      end else if (clr_q_i) begin
        state_q <= IDENT;
      end
    end
  end

  p_valid_lat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(vld_q_i));
  p_odd_is_state_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> state_q == odd_o);
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vld_q_i && !clr_q_i) |=> $stable(state_q));
  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_q_i && !vld_q_i) |=> state_q == IDENT);
  generate
    if (OP == OP_MIN) begin : g_ord_min
      p_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> odd_o <= even_o);
    end else begin : g_ord_up
      p_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> odd_o >= even_o);
    end
  endgenerate
endmodule

// File: rtl/assoc_unfold2.sv
module assoc_unfold2 #(
  parameter int W  = 16,
  parameter int OP = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         valid_i,
  input  logic [W-1:0] x0_i,
  input  logic [W-1:0] x1_i,
  output logic         valid_o,
  output logic [W-1:0] even_o,
  output logic [W-1:0] odd_o
);
  logic         clr_q, vld_q;
  logic [W-1:0] x0_q, pre_q;

  pair_precombine #(.W(W), .OP(OP)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .valid_i(valid_i),
    .x0_i(x0_i), .x1_i(x1_i),
    .clr_q_o(clr_q), .vld_q_o(vld_q), .x0_q_o(x0_q), .pre_q_o(pre_q));

  loop_stage #(.W(W), .OP(OP)) u_loop (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_q_i(clr_q), .vld_q_i(vld_q),
    .x0_q_i(x0_q), .pre_q_i(pre_q),
    .valid_o(valid_o), .even_o(even_o), .odd_o(odd_o));
endmodule

// File: tb/sim_assoc_unfold2.sv
module sim_assoc_unfold2;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, vld = 1'b0;
  logic [W-1:0] x0 = '0, x1 = '0;
  logic [2:0] v_o;
  logic [W-1:0] e_o [3];
  logic [W-1:0] o_o [3];

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assoc_unfold2 #(.W(W), .OP(0)) u0 (.clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .valid_i(vld),
    .x0_i(x0), .x1_i(x1), .valid_o(v_o[0]), .even_o(e_o[0]), .odd_o(o_o[0]));
  assoc_unfold2 #(.W(W), .OP(1)) u1 (.clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .valid_i(vld),
    .x0_i(x0), .x1_i(x1), .valid_o(v_o[1]), .even_o(e_o[1]), .odd_o(o_o[1]));
  assoc_unfold2 #(.W(W), .OP(2)) u2 (.clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .valid_i(vld),
    .x0_i(x0), .x1_i(x1), .valid_o(v_o[2]), .even_o(e_o[2]), .odd_o(o_o[2]));

  function automatic logic [W-1:0] fref(int op, logic [W-1:0] a, logic [W-1:0] b);
    logic [W:0] s;
    case (op)
      0: return (a > b) ? a : b;
      1: return (a < b) ? a : b;
      default: begin
        s = a + b;
        return (s > {1'b0, {W{1'b1}}}) ? {W{1'b1}} : s[W-1:0];
      end
    endcase
  endfunction

  function automatic logic [W-1:0] ident(int op);
    return (op == 1) ? {W{1'b1}} : '0;
  endfunction

  // serial reference state and two-deep expectation pipeline
  logic [W-1:0] ref_y [3];
  bit            pv [2];
  logic [W-1:0] pe [2][3];
  logic [W-1:0] po [2][3];
  string        ptag [2];

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp, int op);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s op=%0d actual=%h expected=%h", req, op, act, exp);
    end
  endtask

  task automatic step(bit v, bit c, logic [W-1:0] a, logic [W-1:0] b, string tag);
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      chk("R4 valid", {15'd0, v_o[k]}, {15'd0, pv[1]}, k);
      if (pv[1]) begin
        chk({"R2 even ", ptag[1]}, e_o[k], pe[1][k], k);
        chk({"R3 odd ", ptag[1]}, o_o[k], po[1][k], k);
      end
    end
    pv[1] = pv[0]; ptag[1] = ptag[0];
    for (int k = 0; k < 3; k++) begin pe[1][k] = pe[0][k]; po[1][k] = po[0][k]; end
    clr = c; vld = v; x0 = a; x1 = b;
    pv[0] = v; ptag[0] = tag;
    for (int k = 0; k < 3; k++) begin
      if (c) ref_y[k] = ident(k);
      if (v) begin
        ref_y[k] = fref(k, ref_y[k], a);
        pe[0][k] = ref_y[k];
        ref_y[k] = fref(k, ref_y[k], b);
        po[0][k] = ref_y[k];
      end
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int k = 0; k < 3; k++) ref_y[k] = ident(k);
    pv[0] = 0; pv[1] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state at ports
    for (int k = 0; k < 3; k++) begin
      chk("R1 valid", {15'd0, v_o[k]}, '0, k);
      chk("R1 even", e_o[k], '0, k);
      chk("R1 odd", o_o[k], '0, k);
    end
    rst_n = 1'b1;
    // R1: first pair starts from identity; R8 operator selection
    step(1, 0, 16'h1234, 16'h0042, "R1 R8 first");
    step(1, 0, 16'h8000, 16'h0001, "R8");
    // R6: idle cycles keep state
    step(0, 0, 16'hFFFF, 16'h0000, "idle");
    step(0, 0, 16'h0000, 16'hFFFF, "idle");
    step(1, 0, 16'h0003, 16'h7000, "R6 after idle");
    // R7: saturation corners
    step(1, 0, 16'hFFFF, 16'hFFFF, "R7 sat");
    step(1, 0, 16'h0000, 16'h0000, "R7 sat hold");
    // R5: clear with pair in the same cycle
    step(1, 1, 16'h0010, 16'h0020, "R5 clr+pair");
    step(1, 0, 16'hFFF0, 16'h0020, "R7 near top");
    // R5: clear alone during idle
    step(0, 1, 16'hAAAA, 16'h5555, "clr idle");
    step(1, 0, 16'h0100, 16'h0200, "R5 after clr");
    // random stream with occasional clears and bubbles
    for (int n = 0; n < 3000; n++) begin
      bit v, c;
      logic [W-1:0] a, b;
      v = ($urandom % 8) != 0;
      c = ($urandom % 23) == 0;
      a = ($urandom % 4 == 0) ? W'($urandom % 16) : W'($urandom);
      b = ($urandom % 5 == 0) ? 16'hFFFF - W'($urandom % 8) : W'($urandom % 4096);
      step(v, c, a, b, c ? "R5 rand" : "R3 rand");
    end
    step(0, 0, '0, '0, "drain");
    step(0, 0, '0, '0, "drain");
    step(0, 0, '0, '0, "drain");
    finish_run();
  end
endmodule